// File: doc/BRIEF.md
# Power-Mode Controller Interrupt Status Register

This block holds the four sticky event flags that a power-mode controller raises towards software. The flags record an attempted write of an illegal per-mode configuration, a request for a mode change that is not permitted, a safe-mode entry forced by hardware, and the end of a mode transition. The flags for configuration errors, mode errors and safe entry are set by single-cycle strobes from the mode controller. The completion flag is derived inside the block from the falling edge of the controller's transition-busy status. It is held off when the transition lands in a low-power mode, because the processor is not running to service it.

Software reaches the block over a small register bus that has two word locations, one for status and one for mask. Each flag is cleared by writing 1 to its bit. A 4-bit mask register enables each flag onto a single interrupt line. Reads have no side effects, and the read data comes back one cycle after the request.

Top module: `mcis_top`

## Requirements
- R1: After a synchronous reset, every status flag and every mask bit is 0, `irq` is 0 and `bus_rdata` is 0.
- R2: Address 0 is the status word. Bit 3 is invalid-configuration, bit 2 is invalid-mode, bit 1 is hardware safe entry and bit 0 is transition-complete. Bits 31:4 always read 0. Address 1 is the mask word, with the same bit positions.
- R3: A status write with a 1 in a flag bit clears that flag. A 0 leaves the flag unchanged, and the values written to bits 31:4 have no effect.
- R4: When a set event and a clearing write hit the same flag in the same cycle, the flag ends up 1.
- R5: A pulse on `evt_bad_cfg` sets bit 3.
- R6: A pulse on `evt_bad_mode` sets bit 2.
- R7: A pulse on `evt_safe` sets bit 1 only when `safe_src_hw` is 1. A software-requested safe entry (`safe_src_hw`=0) leaves the flag unchanged.
- R8: Bit 0 is set in the cycle after `trans_busy` goes from 1 to 0. A rising `trans_busy`, or a `trans_busy` that stays at one level, does not set it.
- R9: Bit 0 is not set when `tgt_mode` holds a low-power code at the falling edge of `trans_busy`. The low-power codes are 8 (halt), 10 (stop) and 13 (standby).
- R10: `irq` is 1 exactly when some flag and its mask bit are both 1. It follows the status and mask registers with no added delay.
- R11: A read (`bus_valid`=1, `bus_we`=0) returns the selected word on `bus_rdata` in the next cycle and changes no flag. In a cycle that follows anything other than a read, `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_bad_cfg | input | 1 | Strobe: illegal per-mode configuration write attempted |
| evt_bad_mode | input | 1 | Strobe: disallowed mode change requested |
| evt_safe | input | 1 | Strobe: safe mode entered |
| safe_src_hw | input | 1 | Qualifies `evt_safe`: 1 means the entry came from a hardware request |
| trans_busy | input | 1 | Mode transition in progress |
| tgt_mode | input | 4 | Target mode code of the current transition |
| bus_valid | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 1 | 0 selects status, 1 selects mask |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after a read |
| irq | output | 1 | OR of the masked flags |

## Verification
The embedded properties assume the event strobes are synchronous to `clk`. They also assume `tgt_mode` is already settled in the cycle where `trans_busy` falls, since it is sampled only in that cycle. The bench meets both assumptions by changing every input at the falling clock edge. It presents the target code together with the falling edge of `trans_busy`, and it raises `trans_busy` for at least one full cycle before each completion. The bench sweeps all sixteen target codes, all 256 pairs of set pattern and clear pattern, and all 256 pairs of flag pattern and mask pattern.

// File: rtl/mcis_pkg.sv
package mcis_pkg;

    localparam int DATA_W = 32;
    localparam int NFLAG  = 4;
    localparam int MODE_W = 4;

    localparam int IDX_DONE    = 0;
    localparam int IDX_SAFE    = 1;
    localparam int IDX_BADMODE = 2;
    localparam int IDX_BADCFG  = 3;

    localparam logic [MODE_W-1:0] MODE_HALT    = 4'd8;
    localparam logic [MODE_W-1:0] MODE_STOP    = 4'd10;
    localparam logic [MODE_W-1:0] MODE_STANDBY = 4'd13;

    typedef logic [NFLAG-1:0] flag_vec_t;

    // packed order places bad_cfg at bit 3 down to done at bit 0
    typedef struct packed {
        logic bad_cfg;
        logic bad_mode;
        logic safe_hw;
        logic done;
    } evt_s;

    typedef enum logic {
        REG_STATUS = 1'b0,
        REG_MASK   = 1'b1
    } reg_sel_e;

    function automatic logic is_low_power(input logic [MODE_W-1:0] m);
        return (m == MODE_HALT) || (m == MODE_STOP) || (m == MODE_STANDBY);
    endfunction

endpackage

// File: rtl/mcis_event_detect.sv
module mcis_event_detect
    import mcis_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bad_cfg_stb,
    input  logic              bad_mode_stb,
    input  logic              safe_stb,
    input  logic              safe_hw,
    input  logic              trans_busy,
    input  logic [MODE_W-1:0] tgt_mode,
    output flag_vec_t         set_vec
);

    logic busy_q;
    logic busy_fall;
    evt_s evt;

    always_ff @(posedge clk) begin
        if (rst) busy_q <= 1'b0;
        else     busy_q <= trans_busy;
    end

    assign busy_fall = busy_q && !trans_busy;

    always_comb begin
        evt.bad_cfg  = bad_cfg_stb;
        evt.bad_mode = bad_mode_stb;
        evt.safe_hw  = safe_stb && safe_hw;
        evt.done     = busy_fall && !is_low_power(tgt_mode);
    end

    assign set_vec = flag_vec_t'(evt);

    // R9: a completion into a low-power target raises nothing
    a_r9_lp_quiet: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !trans_busy && is_low_power(tgt_mode)) |-> !set_vec[IDX_DONE]);

    // R8: a completion into a running mode raises the done event
    a_r8_fall_sets: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !trans_busy && !is_low_power(tgt_mode)) |-> set_vec[IDX_DONE]);

    // R7: a software-sourced safe entry never raises the safe event
    a_r7_sw_safe: assert property (@(posedge clk) disable iff (rst)
        !safe_hw |-> !set_vec[IDX_SAFE]);

endmodule

// File: rtl/mcis_flag_bank.sv
module mcis_flag_bank
    import mcis_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flag_vec_t set_vec,
    input  flag_vec_t clr_vec,
    output flag_vec_t flags
);

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)             flags[i] <= 1'b0;
            else if (set_vec[i]) flags[i] <= 1'b1;
            else if (clr_vec[i]) flags[i] <= 1'b0;
        end

        // R4: a set in the same cycle as a clear leaves the flag at 1
        a_r4_set_wins: assert property (@(posedge clk) disable iff (rst)
            set_vec[i] |=> flags[i]);

        // R3: a clear with no set empties the flag
        a_r3_w1c_clears: assert property (@(posedge clk) disable iff (rst)
            (clr_vec[i] && !set_vec[i]) |=> !flags[i]);

        // R3: with neither set nor clear the flag holds its value
        a_r3_hold: assert property (@(posedge clk) disable iff (rst)
            (!clr_vec[i] && !set_vec[i]) |=> $stable(flags[i]));
    end

endmodule

// File: rtl/mcis_mask_reg.sv
module mcis_mask_reg
    import mcis_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  flag_vec_t wr_val,
    output flag_vec_t mask
);

    always_ff @(posedge clk) begin
        if (rst)        mask <= '0;
        else if (wr_en) mask <= wr_val;
    end

    // R10: the mask only moves on a mask write
    a_r10_mask_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(mask));

endmodule

// File: rtl/mcis_top.sv
module mcis_top
    import mcis_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_bad_cfg,
    input  logic              evt_bad_mode,
    input  logic              evt_safe,
    input  logic              safe_src_hw,
    input  logic              trans_busy,
    input  logic [MODE_W-1:0] tgt_mode,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    localparam int RSV_W = DATA_W - NFLAG;

    reg_sel_e  sel;
    logic      wr_status;
    logic      wr_mask;
    logic      rd_req;
    flag_vec_t set_vec;
    flag_vec_t clr_vec;
    flag_vec_t flags;
    flag_vec_t mask;
    logic      unused_wdata_hi;

    assign sel       = reg_sel_e'(bus_addr);
    assign wr_status = bus_valid &&  bus_we && (sel == REG_STATUS);
    assign wr_mask   = bus_valid &&  bus_we && (sel == REG_MASK);
    assign rd_req    = bus_valid && !bus_we;
    assign clr_vec   = wr_status ? bus_wdata[NFLAG-1:0] : '0;
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NFLAG];

    mcis_event_detect u_evt (
        .clk          (clk),
        .rst          (rst),
        .bad_cfg_stb  (evt_bad_cfg),
        .bad_mode_stb (evt_bad_mode),
        .safe_stb     (evt_safe),
        .safe_hw      (safe_src_hw),
        .trans_busy   (trans_busy),
        .tgt_mode     (tgt_mode),
        .set_vec      (set_vec)
    );

    mcis_flag_bank u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .flags   (flags)
    );

    mcis_mask_reg u_mask (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_mask),
        .wr_val (bus_wdata[NFLAG-1:0]),
        .mask   (mask)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (rd_req) begin
            bus_rdata <= {{RSV_W{1'b0}}, (sel == REG_MASK) ? mask : flags};
        end else begin
            bus_rdata <= '0;
        end
    end

    assign irq = |(flags & mask);

    // R2: reserved read bits stay at zero
    a_r2_rsv_zero: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[DATA_W-1:NFLAG] == '0);

    // R11: a read leaves every flag untouched when no event arrives
    a_r11_read_clean: assert property (@(posedge clk) disable iff (rst)
        (rd_req && set_vec == '0) |=> $stable(flags));

    // R10: an asserted interrupt needs at least one enabled pending flag
    a_r10_irq_src: assert property (@(posedge clk) disable iff (rst)
        irq |-> ($countones(flags & mask) > 0));

endmodule

// File: tb/sim_mcis_top.sv
module sim_mcis_top;
    import mcis_pkg::*;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 200000;

    logic              clk = 1'b0;
    logic              rst;
    logic              evt_bad_cfg, evt_bad_mode, evt_safe, safe_src_hw, trans_busy;
    logic [MODE_W-1:0] tgt_mode;
    logic              bus_valid, bus_we, bus_addr;
    logic [DATA_W-1:0] bus_wdata;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcis_top u0 (
        .clk(clk), .rst(rst),
        .evt_bad_cfg(evt_bad_cfg), .evt_bad_mode(evt_bad_mode),
        .evt_safe(evt_safe), .safe_src_hw(safe_src_hw),
        .trans_busy(trans_busy), .tgt_mode(tgt_mode),
        .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic idle_inputs();
        evt_bad_cfg = 0; evt_bad_mode = 0; evt_safe = 0; safe_src_hw = 0;
        bus_valid = 0; bus_we = 0; bus_addr = 0; bus_wdata = '0;
    endtask

    task automatic bus_write(input logic a, input logic [31:0] d);
        bus_valid = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic bus_read(input logic a, output logic [31:0] d);
        bus_valid = 1; bus_we = 0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        idle_inputs();
    endtask

    // flags: bit3 cfg, bit2 mode, bit1 hw safe, bit0 done via busy fall into mode 0
    task automatic raise(input logic [3:0] s);
        evt_bad_cfg = s[3]; evt_bad_mode = s[2];
        evt_safe = s[1]; safe_src_hw = s[1];
        trans_busy = s[0]; tgt_mode = '0;
        @(negedge clk);
        idle_inputs();
        trans_busy = 0;
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] rd, rd2;
        idle_inputs();
        trans_busy = 0; tgt_mode = '0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 rdata idle", bus_rdata, 32'd0);
        bus_read(0, rd); check("R1 status", rd, 32'd0);
        bus_read(1, rd); check("R1 mask", rd, 32'd0);

        // R5 R6 R7 R8 each flag alone lands at its bit (R2 layout)
        for (int i = 0; i < 4; i++) begin
            raise(4'(1 << i));
            bus_read(0, rd);
            check(i == 3 ? "R5 cfg bit" : i == 2 ? "R6 mode bit" :
                  i == 1 ? "R7 hw safe bit" : "R8 done bit", rd, 32'(1 << i));
            bus_write(0, 32'hF);
        end

        // R3 R2 all set/clear patterns
        for (int s = 0; s < 16; s++) begin
            for (int c = 0; c < 16; c++) begin
                bus_write(0, 32'hF);
                raise(4'(s));
                bus_write(0, 32'(c));
                bus_read(0, rd);
                check("R3 w1c pattern", rd, 32'(s & ~c & 4'hF));
            end
        end

        // R3 reserved bits and zeros ignored
        raise(4'hF);
        bus_write(0, 32'hFFFF_FFF0);
        bus_read(0, rd); check("R3 reserved write", rd, 32'hF);
        bus_write(0, 32'hF);

        // R4 set beats same-cycle clear
        for (int i = 0; i < 3; i++) begin
            bus_valid = 1; bus_we = 1; bus_addr = 0; bus_wdata = 32'hF;
            evt_bad_cfg = (i == 0); evt_bad_mode = (i == 1);
            evt_safe = (i == 2); safe_src_hw = (i == 2);
            @(negedge clk);
            idle_inputs();
            bus_read(0, rd);
            check("R4 set wins", rd, 32'(8 >> i));
            bus_write(0, 32'hF);
        end
        trans_busy = 1; @(negedge clk);
        trans_busy = 0; tgt_mode = 0;
        bus_valid = 1; bus_we = 1; bus_addr = 0; bus_wdata = 32'h1;
        @(negedge clk);
        idle_inputs();
        bus_read(0, rd); check("R4 done set wins", rd, 32'h1);
        bus_write(0, 32'hF);

        // R7 software safe entry
        evt_safe = 1; safe_src_hw = 0;
        @(negedge clk); idle_inputs();
        bus_read(0, rd); check("R7 sw safe ignored", rd, 32'h0);

        // R8 rising and steady busy do not set
        trans_busy = 1; repeat (3) @(negedge clk);
        bus_read(0, rd); check("R8 rise/steady", rd, 32'h0);
        trans_busy = 0; tgt_mode = 0; @(negedge clk);
        repeat (2) @(negedge clk);
        bus_read(0, rd); check("R8 fall once", rd, 32'h1);
        bus_write(0, 32'hF);

        // R9 every target code
        for (int m = 0; m < 16; m++) begin
            trans_busy = 1; @(negedge clk);
            trans_busy = 0; tgt_mode = 4'(m); @(negedge clk);
            tgt_mode = 0;
            bus_read(0, rd);
            check("R9 target code", rd, (m == 8 || m == 10 || m == 13) ? 32'h0 : 32'h1);
            bus_write(0, 32'hF);
        end

        // R10 irq over all flag and mask combinations
        for (int s = 0; s < 16; s++) begin
            for (int m = 0; m < 16; m++) begin
                bus_write(0, 32'hF);
                raise(4'(s));
                bus_write(1, 32'hFFFF_FFF0 | 32'(m));
                check("R10 irq", {31'd0, irq}, {31'd0, ((s & m) != 0)});
            end
        end
        bus_read(1, rd); check("R2 mask readback", rd, 32'hF);

        // R11 reads have no side effect; latency and idle zero
        bus_write(0, 32'hF);
        raise(4'b1010);
        bus_read(0, rd); bus_read(0, rd2);
        check("R11 repeat read", rd2, rd);
        check("R11 read value", rd2, 32'hA);
        @(negedge clk);
        check("R11 idle rdata", bus_rdata, 32'h0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule